// File: doc/BRIEF.md
# Polled Accelerator Launch Frame

This block is a small register frame placed between a processor's register bus and a group of up to eight accelerators. Software fills a 512-bit operation payload through eight 64-bit data words. It then writes one launch word that names an opcode and a target accelerator. The frame checks the launch and raises an issue request carrying the payload, opcode and index to the selected unit. It records the outcome in a launch-response register, which software polls. No interrupt exists.

Work that outlives its launch is followed through a single status register that the accelerator updates over a strobe. Each such update raises a one-cycle wake pulse that can rouse a core sleeping in a wait-for-event loop. When an accelerator reports a translation fault, it parks its operation. Software clears the fault and then launches the dedicated resolve opcode to let the operation continue.

Top module: `accel_launch_frame`

## Requirements
- R1: Word addresses 0 to 7 are the 64-bit payload words. Writing one and reading it back returns the written value.
- R2: Address 8 is the launch word, with opcode in bits [7:0] and accelerator index in bits [11:8]. A legal launch sets the launch response to pending (state 1, code 0) on the next cycle. It also raises `iss_valid` with `iss_index`, `iss_opcode` and `iss_payload`, where payload word 0 sits in bits [63:0].
- R3: The issue request holds its index, opcode and payload unchanged until `iss_ready` is seen. Payload-word writes made while the request is outstanding are ignored.
- R4: A launch written before the previous one has completed, whether still issuing or awaiting its response, sets the launch response to state 3 with code 1 (busy). It issues nothing new, and the earlier launch still completes normally.
- R5: A launch whose index is at or above `N_ACC` completes at once with state 3 and code 2, and issues nothing. This check takes priority over the opcode check.
- R6: Opcode 0x00 is refused with state 3 and code 3. Opcode 0xFF (resolve) is refused the same way unless a fault reported by the accelerator is still unresolved.
- R7: Address 9 reads the launch response as state in bits [1:0] and code in bits [5:2]. When an issued launch gets `lr_valid`, the response becomes state 2 with code 0 if `lr_err` is 0. It becomes state 3 with code 4 if `lr_err` is 1.
- R8: Address 10 reads the status register in bits [1:0], with 0 idle, 1 running, 2 done and 3 fault. A `st_upd` strobe loads `st_code` into it. In the cycle the new value first shows, `wake_evt` is high, and it is high for exactly that one cycle per strobe.
- R9: Reading the status register returns its current value. If that value is done or fault, the register becomes idle afterwards without any wake pulse. Running and idle are left unchanged by a read.
- R10: After a fault status update, one resolve launch is accepted and issued with opcode 0xFF, even if the fault status was already read away. A second resolve with no new fault is refused as a bad opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives the status read-clear) |
| reg_addr | input | AW (4) | Word address |
| reg_wdata | input | DW (64) | Write data |
| reg_rdata | output | DW (64) | Read data for `reg_addr`, combinational |
| iss_valid | output | 1 | Launch issue request |
| iss_ready | input | 1 | Selected accelerator takes the launch |
| iss_index | output | IDXW (3) | Target accelerator |
| iss_opcode | output | OPW (8) | Operation code |
| iss_payload | output | DW*NW (512) | Operation payload |
| lr_valid | input | 1 | Launch response from the accelerator |
| lr_err | input | 1 | Accelerator refused the launch |
| st_upd | input | 1 | Status update strobe |
| st_code | input | 2 | New status value |
| wake_evt | output | 1 | One-cycle status-change event |

## Verification
Launches are tried with legal operations, with out-of-range indices, and with reserved and resolve opcodes, both with and without an outstanding fault. This separates the index check, the opcode check and their relative priority. Busy launches are sent both while the issue waits on `iss_ready` and after the handshake while the response is still awaited, which shows that the earlier launch survives either case. Status updates with running, done and fault are each followed by reads, which tells the clearing values apart from the sticky ones and the strobe-driven pulse from the silent read-clear.

// File: rtl/accel_launch_frame.sv
module accel_launch_frame #(
  parameter int N_ACC = 8,
  parameter int DW    = 64,
  parameter int NW    = 8,
  parameter int OPW   = 8,
  localparam int AW   = $clog2(NW + 3),
  localparam int IDXW = (N_ACC > 1) ? $clog2(N_ACC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [IDXW-1:0]   iss_index,
  output logic [OPW-1:0]    iss_opcode,
  output logic [DW*NW-1:0]  iss_payload,
  input  logic              lr_valid,
  input  logic              lr_err,
  input  logic              st_upd,
  input  logic [1:0]        st_code,
  output logic              wake_evt
);
  localparam int WIW = (NW > 1) ? $clog2(NW) : 1;
  localparam logic [AW-1:0] ADR_LAUNCH = AW'(NW);
  localparam logic [AW-1:0] ADR_LRESP  = AW'(NW + 1);
  localparam logic [AW-1:0] ADR_STATUS = AW'(NW + 2);
  localparam logic [OPW-1:0] OPC_RESOLVE = '1;

  localparam logic [1:0] LR_IDLE = 2'd0, LR_PEND = 2'd1, LR_ACC = 2'd2, LR_ERR = 2'd3;
  localparam logic [3:0] E_OK = 4'd0, E_BUSY = 4'd1, E_IDX = 4'd2, E_OPC = 4'd3, E_REJ = 4'd4;
  localparam logic [1:0] ST_IDLE = 2'd0, ST_DONE = 2'd2, ST_FAULT = 2'd3;

  typedef enum logic [1:0] {L_IDLE, L_ISSUE, L_WAIT} lstate_t;

  lstate_t           lstate_q;
  logic [DW-1:0]     data_q [NW];
  logic [1:0]        lr_state_q;
  logic [3:0]        lr_err_q;
  logic [1:0]        status_q;
  logic              fault_q;
  logic              wake_q;
  logic [IDXW-1:0]   idx_q;
  logic [OPW-1:0]    opc_q;

  wire             launch_wr = reg_wr && (reg_addr == ADR_LAUNCH);
  wire             data_wr   = reg_wr && (reg_addr < ADR_LAUNCH);
  wire             rd_status = reg_rd && (reg_addr == ADR_STATUS);
  wire [3:0]       l_idx     = reg_wdata[11:8];
  wire [OPW-1:0]   l_opc     = reg_wdata[OPW-1:0];
  wire             busy      = (lstate_q != L_IDLE);
  wire             bad_idx   = (32'(l_idx) >= N_ACC);
  wire             is_resolve = (l_opc == OPC_RESOLVE);
  wire             bad_opc   = (l_opc == '0) || (is_resolve && !fault_q);

  assign iss_valid  = (lstate_q == L_ISSUE);
  assign iss_index  = idx_q;
  assign iss_opcode = opc_q;
  assign wake_evt   = wake_q;

  for (genvar g = 0; g < NW; g++) begin : g_pay
    assign iss_payload[g*DW +: DW] = data_q[g];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < ADR_LAUNCH)       reg_rdata = data_q[reg_addr[WIW-1:0]];
    else if (reg_addr == ADR_LRESP)  reg_rdata[5:0] = {lr_err_q, lr_state_q};
    else if (reg_addr == ADR_STATUS) reg_rdata[1:0] = status_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lstate_q   <= L_IDLE;
      lr_state_q <= LR_IDLE;
      lr_err_q   <= E_OK;
      status_q   <= ST_IDLE;
      fault_q    <= 1'b0;
      wake_q     <= 1'b0;
      idx_q      <= '0;
      opc_q      <= '0;
      for (int i = 0; i < NW; i++) data_q[i] <= '0;
    end else begin
      if (data_wr && lstate_q != L_ISSUE) data_q[reg_addr[WIW-1:0]] <= reg_wdata;

      unique case (lstate_q)
        L_IDLE: if (launch_wr) begin
          if (bad_idx) begin
            lr_state_q <= LR_ERR; lr_err_q <= E_IDX;
          end else if (bad_opc) begin
            lr_state_q <= LR_ERR; lr_err_q <= E_OPC;
          end else begin
            lr_state_q <= LR_PEND; lr_err_q <= E_OK;
            idx_q      <= l_idx[IDXW-1:0];
            opc_q      <= l_opc;
            lstate_q   <= L_ISSUE;
            if (is_resolve) fault_q <= 1'b0;
          end
        end
        L_ISSUE: begin
          if (launch_wr) begin lr_state_q <= LR_ERR; lr_err_q <= E_BUSY; end
          if (iss_ready) lstate_q <= L_WAIT;
        end
        L_WAIT: begin
          if (lr_valid) begin
            lr_state_q <= lr_err ? LR_ERR : LR_ACC;
            lr_err_q   <= lr_err ? E_REJ : E_OK;
            lstate_q   <= L_IDLE;
          end else if (launch_wr) begin
            lr_state_q <= LR_ERR; lr_err_q <= E_BUSY;
          end
        end
        default: lstate_q <= L_IDLE;
      endcase

      if (st_upd) begin
        status_q <= st_code;
        fault_q  <= (st_code == ST_FAULT);
      end else if (rd_status && (status_q == ST_DONE || status_q == ST_FAULT)) begin
        status_q <= ST_IDLE;
      end
      wake_q <= st_upd;
    end
  end
endmodule

module accel_launch_frame_chk #(
  parameter int N_ACC = 8,
  parameter int AW    = 4,
  parameter int IDXW  = 3,
  parameter int OPW   = 8,
  parameter int PW    = 512
) (
  input logic            clk,
  input logic            rst_n,
  input logic            launch_wr,
  input logic            rd_status,
  input logic [3:0]      l_idx,
  input logic            busy,
  input logic            iss_valid,
  input logic            iss_ready,
  input logic [IDXW-1:0] iss_index,
  input logic [OPW-1:0]  iss_opcode,
  input logic [PW-1:0]   iss_payload,
  input logic [1:0]      lr_state,
  input logic [3:0]      lr_err,
  input logic [1:0]      status,
  input logic            st_upd,
  input logic [1:0]      st_code,
  input logic            wake_evt
);
  AST_ISSUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready |=> iss_valid && $stable(iss_index) && $stable(iss_opcode) && $stable(iss_payload)); // R3
  AST_ISSUE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (lr_state == 2'd1) || (lr_state == 2'd3 && lr_err == 4'd1)); // R4
  AST_BAD_INDEX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    launch_wr && !busy && (32'(l_idx) >= N_ACC) |=> !iss_valid && lr_state == 2'd3 && lr_err == 4'd2); // R5
  AST_WAKE_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    st_upd |=> wake_evt && status == $past(st_code)); // R8
  AST_WAKE_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !st_upd |=> !wake_evt); // R8
  AST_STATUS_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status && !st_upd && status[1] |=> status == 2'd0); // R9
endmodule

bind accel_launch_frame accel_launch_frame_chk #(
  .N_ACC(N_ACC), .AW(AW), .IDXW(IDXW), .OPW(OPW), .PW(DW*NW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .launch_wr(launch_wr), .rd_status(rd_status),
  .l_idx(l_idx), .busy(busy), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_index(iss_index), .iss_opcode(iss_opcode), .iss_payload(iss_payload),
  .lr_state(lr_state_q), .lr_err(lr_err_q), .status(status_q),
  .st_upd(st_upd), .st_code(st_code), .wake_evt(wake_evt)
);

// File: tb/accel_launch_frame_bench.sv
module accel_launch_frame_bench;
  localparam int NA = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, iss_ready = 0, lr_valid = 0, lr_err = 0, st_upd = 0;
  logic [3:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic [1:0] st_code = '0;
  logic iss_valid, wake_evt;
  logic [2:0] iss_index;
  logic [7:0] iss_opcode;
  logic [511:0] iss_payload;
  int unsigned n_chk = 0, n_bad = 0;
  logic [63:0] r;

  always #10 clk = ~clk;

  accel_launch_frame #(.N_ACC(NA)) u_accel_launch_frame (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_index(iss_index), .iss_opcode(iss_opcode), .iss_payload(iss_payload),
    .lr_valid(lr_valid), .lr_err(lr_err), .st_upd(st_upd), .st_code(st_code), .wake_evt(wake_evt));

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] d);
    reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic launch(input logic [3:0] idx, input logic [7:0] opc);
    wr(4'd8, {52'd0, idx, opc});
  endtask

  task automatic handshake();
    iss_ready = 1; @(negedge clk); iss_ready = 0;
  endtask

  task automatic respond(input logic e);
    lr_valid = 1; lr_err = e; @(negedge clk); lr_valid = 0; lr_err = 0;
  endtask

  task automatic update(input logic [1:0] c);
    st_upd = 1; st_code = c; @(negedge clk); st_upd = 0;
  endtask

  task automatic t_reset();
    rd(4'd9, r);  chk("R7 reset lresp", r, 64'd0);
    rd(4'd10, r); chk("R8 reset status", r, 64'd0);
    chk("R2 reset iss_valid", iss_valid, 0);
    chk("R8 reset wake", wake_evt, 0);
  endtask

  task automatic t_data();
    for (int i = 0; i < 8; i++) wr(4'(i), 64'hA5A5_0000_0000_0000 | 64'(i * 17));
    for (int i = 0; i < 8; i++) begin
      rd(4'(i), r); chk("R1 data readback", r, 64'hA5A5_0000_0000_0000 | 64'(i * 17));
    end
  endtask

  task automatic t_launch_ok();
    launch(4'd3, 8'h21);
    rd(4'd9, r); chk("R2 lresp pending", r, 64'd1);
    chk("R2 iss_valid", iss_valid, 1);
    chk("R2 iss_index", iss_index, 3);
    chk("R2 iss_opcode", iss_opcode, 8'h21);
    chk("R2 payload word1", iss_payload[127:64], 64'hA5A5_0000_0000_0011);
    wr(4'd2, 64'hDEAD);
    rd(4'd2, r); chk("R3 data write ignored", r, 64'hA5A5_0000_0000_0022);
    chk("R3 payload stable", iss_payload[191:128], 64'hA5A5_0000_0000_0022);
    launch(4'd1, 8'h05);
    rd(4'd9, r); chk("R4 busy while issuing", r, 64'h7);
    chk("R4 no new index", iss_index, 3);
    chk("R4 no new opcode", iss_opcode, 8'h21);
    handshake();
    chk("R3 issue dropped after ready", iss_valid, 0);
    launch(4'd2, 8'h09);
    rd(4'd9, r); chk("R4 busy while awaiting response", r, 64'h7);
    chk("R4 no issue from busy launch", iss_valid, 0);
    respond(0);
    rd(4'd9, r); chk("R7 accepted", r, 64'h2);
    wr(4'd2, 64'hBEEF);
    rd(4'd2, r); chk("R1 data write after issue", r, 64'hBEEF);
  endtask

  task automatic t_reject();
    launch(4'd5, 8'h07);
    chk("R2 top legal index issues", iss_valid, 1);
    handshake();
    respond(1);
    rd(4'd9, r); chk("R7 accelerator refusal", r, 64'h13);
  endtask

  task automatic t_bad();
    launch(4'd6, 8'h01);
    rd(4'd9, r); chk("R5 index at limit", r, 64'hB);
    chk("R5 nothing issued", iss_valid, 0);
    launch(4'd15, 8'h00);
    rd(4'd9, r); chk("R5 index priority over opcode", r, 64'hB);
    launch(4'd2, 8'h00);
    rd(4'd9, r); chk("R6 opcode zero", r, 64'hF);
    launch(4'd0, 8'hFF);
    rd(4'd9, r); chk("R6 resolve without fault", r, 64'hF);
    chk("R6 nothing issued", iss_valid, 0);
  endtask

  task automatic t_status();
    update(2'd1);
    chk("R8 wake on update", wake_evt, 1);
    rd(4'd10, r); chk("R8 status running", r, 64'd1);
    chk("R8 wake one cycle", wake_evt, 0);
    rd(4'd10, r); chk("R9 running survives read", r, 64'd1);
    update(2'd2);
    rd(4'd10, r); chk("R9 read returns done", r, 64'd2);
    chk("R9 no wake on clear", wake_evt, 0);
    rd(4'd10, r); chk("R9 done cleared", r, 64'd0);
  endtask

  task automatic t_resolve();
    update(2'd3);
    rd(4'd10, r); chk("R8 fault shown", r, 64'd3);
    rd(4'd10, r); chk("R9 fault cleared", r, 64'd0);
    launch(4'd1, 8'hFF);
    rd(4'd9, r); chk("R10 resolve pending", r, 64'd1);
    chk("R10 resolve opcode", iss_opcode, 8'hFF);
    chk("R10 resolve index", iss_index, 1);
    handshake();
    respond(0);
    launch(4'd1, 8'hFF);
    rd(4'd9, r); chk("R10 second resolve refused", r, 64'hF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_data();
    t_launch_ok();
    t_reject();
    t_bad();
    t_status();
    t_resolve();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule